// File: doc/BRIEF.md
# Interrupt status and mask controller

This block collects interrupt events from up to sixteen peripheral sources and presents a single level-sensitive request to the processor. Each source signals an event with a one-cycle pulse. The pulse latches a pending bit in a status register. A second register, the mask, selects which pending bits may reach the processor. The request output stays high for as long as at least one pending bit is also enabled.

Software reaches both registers through a simple register bus. The bus has an address, a write strobe, write data and combinational read data. Writing the status register acknowledges events by clearing bits, never by setting them. The written word is ANDed into the pending bits. A zero clears the matching bit and a one leaves it alone, so a handler can acknowledge only the sources it has served without a read-modify-write. Writing the mask replaces it outright. A dedicated input carries the summary request from the DMA interrupt logic and is latched into status bit 3.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[i]` sets status bit i at the next rising clock edge, and the bit stays set until it is acknowledged or reset.
- R2: A write to offset 0x70 makes the new status equal to the old status AND `bus_wdata[15:0]`: bits written 0 are cleared and bits written 1 keep their value.
- R3: A write to offset 0x74 replaces the whole mask with `bus_wdata[15:0]`, and the mask changes at no other time except reset.
- R4: `cpu_irq` is high exactly when some bit is set in both status and mask. It follows every status or mask update in the cycle after the clock edge that made the update.
- R5: Writing the mask so that it enables a bit that is already pending raises `cpu_irq` right after that write's clock edge, with no new source pulse.
- R6: When a source pulse and a status write that clears the same bit land in the same cycle, the pulse wins and the bit stays set. Pulses on bits the write does not touch are also latched.
- R7: A pulse on `dma_summary` sets status bit 3, in the same way as a pulse on `src_pulse[3]`.
- R8: The read data is the status at offset 0x70 and the mask at offset 0x74, each in bits 15:0 with bits 31:16 zero. Any other offset reads as zero.
- R9: A write to any offset other than 0x70 or 0x74 changes neither status nor mask.
- R10: A synchronous reset clears status and mask, so `cpu_irq` is low after the reset edge. Source pulses during reset are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pulse | input | 16 | One-cycle event pulses, one per source bit |
| dma_summary | input | 1 | One-cycle summary event from the DMA interrupt logic, latched into bit 3 |
| bus_addr | input | 8 | Register offset inside the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; bits 15:0 are used |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cpu_irq | output | 1 | Level request to the processor |

## Verification
The two functions that can meet in one cycle are event capture from a source pulse and acknowledgement through a status write. The bench provokes this by driving a pulse and a clearing status write on the same clock edge. Some pulses hit a bit the write clears, and some hit a bit the write does not touch. It then reads the status back and expects every pulsed bit set, whatever the written word held. Unmasking during a standing event is judged the same way: the request output must be high at the first sample after the mask write, with no pulse in between.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // Next value of one pending bit: an acknowledge write ANDs in the written
  // bit, and a raise in the same cycle always leaves the bit set.
  function automatic logic pend_next(input logic old_b,
                                     input logic ack_wr,
                                     input logic wr_b,
                                     input logic raise_b);
    logic kept;
    kept = ack_wr ? (old_b & wr_b) : old_b;
    return kept | raise_b;
  endfunction

  // True when the offset selects a given register.
  function automatic logic offset_hit(input logic [7:0] addr,
                                      input logic [7:0] ofs);
    return addr == ofs;
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  STAT_OFS = 8'h70,
  parameter logic [7:0]  MASK_OFS = 8'h74
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output logic              stat_sel,
  output logic              mask_sel,
  output logic              stat_wr,
  output logic              mask_wr
);
  import irq_ctrl_pkg::*;

  logic [7:0] addr8;

  always_comb begin
    addr8 = '0;
    addr8[ADDR_W-1:0] = bus_addr;
  end

  assign stat_sel = offset_hit(addr8, STAT_OFS);
  assign mask_sel = offset_hit(addr8, MASK_OFS);
  assign stat_wr  = bus_wr & stat_sel;
  assign mask_wr  = bus_wr & mask_sel;
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_wr,
  input  logic [NUM_SRC-1:0] ack_data,
  input  logic [NUM_SRC-1:0] raise_vec,
  output logic [NUM_SRC-1:0] stat_q
);
  import irq_ctrl_pkg::*;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= pend_next(stat_q[i], ack_wr, ack_data[i], raise_vec[i]);
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [NUM_SRC-1:0] load_data,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (load) mask_q <= load_data;
  end
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl #(
  parameter int         NUM_SRC  = 16,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter int         DMA_BIT  = 3,
  parameter logic [7:0] STAT_OFS = 8'h70,
  parameter logic [7:0] MASK_OFS = 8'h74
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               dma_summary,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               cpu_irq
);
  logic               stat_sel, mask_sel;
  logic               stat_wr, mask_wr;
  logic [NUM_SRC-1:0] wdata_lo;
  logic [NUM_SRC-1:0] raise_vec;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] enabled_vec;

  assign wdata_lo = bus_wdata[NUM_SRC-1:0];

  always_comb begin
    raise_vec = src_pulse;
    raise_vec[DMA_BIT] = src_pulse[DMA_BIT] | dma_summary;
  end

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr),
    .stat_sel(stat_sel), .mask_sel(mask_sel),
    .stat_wr(stat_wr),   .mask_wr(mask_wr)
  );

  irq_status_bits #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst(rst), .ack_wr(stat_wr), .ack_data(wdata_lo),
    .raise_vec(raise_vec), .stat_q(stat_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .load(mask_wr), .load_data(wdata_lo),
    .mask_q(mask_q)
  );

  assign enabled_vec = stat_q & mask_q;
  assign cpu_irq     = |enabled_vec;

  always_comb begin
    bus_rdata = '0;
    if (stat_sel)      bus_rdata[NUM_SRC-1:0] = stat_q;
    else if (mask_sel) bus_rdata[NUM_SRC-1:0] = mask_q;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               stat_wr,
  input logic               mask_wr,
  input logic [NUM_SRC-1:0] wdata_lo,
  input logic [NUM_SRC-1:0] raise_vec,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               cpu_irq
);
  AST_NEW_PEND_FROM_RAISE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(raise_vec)) == '0)); // R1

  AST_ACK_ANDS: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ((stat_q & ~$past(raise_vec)) == ($past(stat_q) & $past(wdata_lo) & ~$past(raise_vec)))); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(wdata_lo))); // R3

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_q)); // R9

  AST_UNMASK_PEND: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && ((stat_q & wdata_lo) != '0)) |=> cpu_irq); // R5

  AST_RAISE_WINS: assert property (@(posedge clk) disable iff (rst)
    (raise_vec != '0) |=> ((stat_q & $past(raise_vec)) == $past(raise_vec))); // R6

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_irq) |-> $past(stat_wr || mask_wr || (raise_vec != '0))); // R4
endmodule

bind irq_stat_mask_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .stat_wr(stat_wr), .mask_wr(mask_wr),
  .wdata_lo(wdata_lo), .raise_vec(raise_vec), .stat_q(stat_q),
  .mask_q(mask_q), .cpu_irq(cpu_irq)
);

// File: tb/irq_stat_mask_ctrl_tb.sv
module irq_stat_mask_ctrl_tb;
  localparam logic [7:0] STAT_A  = 8'h70;
  localparam logic [7:0] MASK_A  = 8'h74;
  localparam logic [7:0] OTHER_A = 8'h40;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] src_pulse;
  logic        dma_summary;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] exp_stat;
  logic [15:0] exp_mask;

  always #5 clk = ~clk;

  irq_stat_mask_ctrl u_dut (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .dma_summary(dma_summary),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // One bus write and/or pulses on one clock edge; returns at the next negedge.
  task automatic cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] p, input logic dma);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; src_pulse = p; dma_summary = dma;
    @(negedge clk);
    bus_wr = 1'b0; src_pulse = '0; dma_summary = 1'b0;
  endtask

  function automatic logic irq_model();
    return (exp_stat & exp_mask) != 16'h0;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    @(negedge clk);
    rst = 1'b1; src_pulse = 16'hFFFF;
    @(negedge clk);
    src_pulse = '0; rst = 1'b0;
    exp_stat = '0; exp_mask = '0;
    rd(STAT_A, d); check("R10 status after reset", d, 32'h0);
    rd(MASK_A, d); check("R10 mask after reset", d, 32'h0);
    check("R10 irq after reset", {31'h0, cpu_irq}, 32'h0);
  endtask

  task automatic t_raise();
    logic [31:0] d;
    cycle(1'b0, OTHER_A, 32'h0, 16'h0005, 1'b0);
    exp_stat = 16'h0005;
    rd(STAT_A, d); check("R1 pulses latched", d, {16'h0, exp_stat});
    cycle(1'b0, OTHER_A, 32'h0, 16'h0000, 1'b0);
    rd(STAT_A, d); check("R1 bits held", d, {16'h0, exp_stat});
    check("R4 irq low while masked", {31'h0, cpu_irq}, {31'h0, irq_model()});
  endtask

  task automatic t_unmask();
    logic [31:0] d;
    cycle(1'b1, MASK_A, 32'hABCD_0004, 16'h0, 1'b0);
    exp_mask = 16'h0004;
    check("R5 irq right after unmask", {31'h0, cpu_irq}, 32'h1);
    rd(MASK_A, d); check("R3 mask loaded, R8 upper zero", d, {16'h0, exp_mask});
  endtask

  task automatic t_ack();
    logic [31:0] d;
    cycle(1'b1, STAT_A, 32'hFFFF_FFFB, 16'h0, 1'b0);
    exp_stat = exp_stat & 16'hFFFB;
    rd(STAT_A, d); check("R2 zero bit cleared", d, {16'h0, exp_stat});
    check("R4 irq drops after ack", {31'h0, cpu_irq}, {31'h0, irq_model()});
    cycle(1'b1, STAT_A, 32'h0000_FFFF, 16'h0, 1'b0);
    rd(STAT_A, d); check("R2 ones keep bits", d, {16'h0, exp_stat});
  endtask

  task automatic t_collide();
    logic [31:0] d;
    cycle(1'b1, STAT_A, 32'h0, 16'h0021, 1'b0);
    exp_stat = (exp_stat & 16'h0) | 16'h0021;
    rd(STAT_A, d); check("R6 pulse beats ack", d, {16'h0, exp_stat});
    cycle(1'b1, STAT_A, 32'h0000_FFDF, 16'h0100, 1'b0);
    exp_stat = (exp_stat & 16'hFFDF) | 16'h0100;
    rd(STAT_A, d); check("R6 untouched pulse latched", d, {16'h0, exp_stat});
  endtask

  task automatic t_dma();
    logic [31:0] d;
    cycle(1'b1, STAT_A, 32'h0, 16'h0, 1'b0);
    exp_stat = '0;
    cycle(1'b0, OTHER_A, 32'h0, 16'h0, 1'b1);
    exp_stat = 16'h0008;
    rd(STAT_A, d); check("R7 dma sets bit 3", d, {16'h0, exp_stat});
    cycle(1'b1, MASK_A, 32'h0000_0008, 16'h0, 1'b0);
    exp_mask = 16'h0008;
    check("R4 irq from dma bit", {31'h0, cpu_irq}, {31'h0, irq_model()});
  endtask

  task automatic t_other_addr();
    logic [31:0] d;
    cycle(1'b1, OTHER_A, 32'h0, 16'h0, 1'b0);
    rd(STAT_A, d); check("R9 status unchanged", d, {16'h0, exp_stat});
    rd(MASK_A, d); check("R9 mask unchanged", d, {16'h0, exp_mask});
    rd(OTHER_A, d); check("R8 other offset reads zero", d, 32'h0);
    cycle(1'b1, MASK_A, 32'h0000_0001, 16'h0, 1'b0);
    exp_mask = 16'h0001;
    rd(MASK_A, d); check("R3 mask replaced", d, {16'h0, exp_mask});
    check("R4 irq low after remask", {31'h0, cpu_irq}, {31'h0, irq_model()});
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    cycle(1'b1, MASK_A, 32'h0000_FFFF, 16'h0, 1'b0);
    check("R4 irq high before reset", {31'h0, cpu_irq}, 32'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(STAT_A, d); check("R10 status cleared", d, 32'h0);
    rd(MASK_A, d); check("R10 mask cleared", d, 32'h0);
    check("R10 irq low", {31'h0, cpu_irq}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; src_pulse = '0; dma_summary = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    exp_stat = '0; exp_mask = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_raise();
    t_unmask();
    t_ack();
    t_collide();
    t_dma();
    t_other_addr();
    t_reset_again();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule